// File: doc/BRIEF.md
# Card data FIFO transfer engine

This block moves payload between a host-facing word FIFO (sixteen 32-bit entries by default) and a card data port that carries one byte per transfer. The host programs a byte length, then writes the control word with the enable bit set. That write loads a byte counter, and the engine runs until the counter reaches zero. The direction bit picks the flow. In the card-to-FIFO direction, incoming bytes are packed into words least significant byte first. In the FIFO-to-card direction, words are unpacked and sent low byte first.

Both card-side streams use valid/ready. A byte moves on a clock edge where valid and ready are both high. The engine holds `wr_valid` and `wr_data` steady until the card accepts the byte. It drops `rd_ready` whenever it cannot take a byte: the FIFO is full, the card has not reported data ready, the counter is zero, or reads are on hold after a host pop. The host side is register-like. Pushes and pops are single-cycle strobes, and `pop_data` shows the head word during the pop cycle. The status outputs are the per-direction FIFO flag groups, the end-of-data flags and a remaining-word readback.

Top module: `cardfifo_xfer`

## Requirements
- R1: After reset the engine is disabled. `data_end`, `block_end`, `tx_flags`, `rx_flags`, `word_count`, `rd_ready` and `wr_valid` are all zero.
- R2: A `ctrl_wr` with `ctrl_wdata[0]`=1 loads the byte counter from the 16-bit length register and clears `data_end` and `block_end`. `word_count` always equals (remaining bytes + 3) / 4, rounded down, so a length of 65535 reads back 16384. Writing `ctrl_wdata[0]`=0 disables the engine. The counter never rises except by such a load.
- R3: With `ctrl_wdata[1]`=1 (card to FIFO), accepted bytes are packed least significant byte first, at up to one byte per clock. Each fourth byte pushes the completed word.
- R4: When the last byte of a read arrives with fewer than four bytes in the word, the partial word is still pushed, with its unused upper bytes set to zero.
- R5: `rd_ready` is low while the FIFO holds 16 words.
- R6: `rd_ready` is low while `card_data_ready` is low.
- R7: After a host pop of a non-empty FIFO, `rd_ready` stays low until `status_poll` is pulsed. A pop in the same cycle as a poll keeps the hold in place.
- R8: With `ctrl_wdata[1]`=0 (FIFO to card), the engine takes a word from the FIFO and offers its bytes low byte first. Each accepted byte decrements the counter. `wr_valid` and `wr_data` stay stable while `wr_ready` is low. When the counter reaches zero, any unsent bytes of the current word are dropped and `wr_valid` stays low.
- R9: One cycle after the counter is zero on an enabled engine, `data_end` and `block_end` are both set, and they stay set until the next enabling load.
- R10: When the counter is zero and the FIFO is empty, the engine clears its enable (`xfer_enabled`) on the next edge, and both flag groups read zero one cycle later. While the FIFO still holds words, the engine stays enabled.
- R11: While the engine is active, the flag group for the current direction is set and the other group is zero (`rx_flags` for reads, `tx_flags` for writes). The flag bits are: bit0 active, always 1; bit1 empty, when the FIFO count is 0; bit2 available, when the count is not 0; bit3 full, at 16; bit4 half, which in `tx_flags` means count <= 8 and in `rx_flags` means count >= 8. The flags are registered one cycle after the count.
- R12: A host push is ignored while the byte counter is zero. A pop from an empty FIFO returns zero.
- R13: The FIFO is circular, with the read position and fill count wrapping modulo 16, and it delivers words in arrival order across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 2 | Bit0 enable/load, bit1 direction (1 = card to FIFO) |
| len_wr | input | 1 | Length write strobe |
| len_wdata | input | 16 | Transfer length in bytes |
| push_strobe | input | 1 | Host writes one word into the FIFO |
| push_data | input | 32 | Word pushed by the host |
| pop_strobe | input | 1 | Host removes the head word |
| pop_data | output | 32 | Head word, or zero when the FIFO is empty |
| status_poll | input | 1 | Host read of status or word count; releases the read hold |
| card_data_ready | input | 1 | Card has read data available |
| rd_valid | input | 1 | Card byte valid (card to FIFO) |
| rd_data | input | 8 | Card byte |
| rd_ready | output | 1 | Engine accepts a card byte |
| wr_valid | output | 1 | Engine offers a byte to the card |
| wr_data | output | 8 | Byte to card |
| wr_ready | input | 1 | Card accepts the byte |
| xfer_enabled | output | 1 | Engine enable bit |
| data_end | output | 1 | Counter reached zero |
| block_end | output | 1 | Block finished (set with data_end) |
| tx_flags | output | 5 | FIFO flags for the FIFO-to-card direction |
| rx_flags | output | 5 | FIFO flags for the card-to-FIFO direction |
| word_count | output | 15 | (remaining bytes + 3) / 4 |

## Verification
The bench ends a read on a partial word, two bytes into it. A packer that forgot the final flush would strand those bytes, and one that left stale lanes would return nonzero upper bytes. It fills the FIFO to 16 words, checks that intake stalls, then pops once without polling to show that the hold keeps the engine from refilling the free slot; the later drain runs across the pointer wrap, so a broken wrap would misorder the scoreboard words. A write run under alternating back-pressure stops mid-word: a design that kept going past the count would emit extra bytes, and one that did not hold its data would send bytes twice or skip them. Zero-length and maximum-length loads check the end flags, the auto-disable and the rounding of the word readback at its widest value.

// File: rtl/cfx_pkg.sv
package cfx_pkg;
  // flag bit positions shared by both direction groups
  localparam int FLG_ACTIVE = 0;
  localparam int FLG_EMPTY  = 1;
  localparam int FLG_AVAIL  = 2;
  localparam int FLG_FULL   = 3;
  localparam int FLG_HALF   = 4;
  localparam int FLG_N      = 5;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_DIR_BIT = 1;

  typedef enum logic {
    XFER_TO_CARD   = 1'b0,
    XFER_FROM_CARD = 1'b1
  } xfer_dir_e;

  // packed so that bit positions match the FLG_* constants
  typedef struct packed {
    logic half;
    logic full;
    logic avail;
    logic empty;
    logic active;
  } fifo_flags_t;
endpackage

// File: rtl/cfx_word_fifo.sv
module cfx_word_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [WORD_W-1:0]            push_data,
  input  logic                         pop,
  output logic [WORD_W-1:0]            head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  wr_ptr;
  logic [CNT_W-1:0]  count_q;

  // write slot = read position + fill count, wrapping modulo DEPTH
  assign wr_ptr = rd_ptr + count_q[PTR_W-1:0];
  assign head   = mem[rd_ptr];
  assign count  = count_q;
  assign full   = (count_q == CNT_W'(DEPTH));
  assign empty  = (count_q == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R12
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R13
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/cfx_byte_lane.sv
module cfx_byte_lane #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  // packing side (card to FIFO)
  input  logic              rd_fire,
  input  logic [7:0]        rd_byte,
  input  logic              last_byte,
  output logic              pk_push,
  output logic [WORD_W-1:0] pk_word,
  // unpacking side (FIFO to card)
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              wr_fire,
  output logic              up_valid,
  output logic [7:0]        up_byte
);
  localparam int BYTES  = WORD_W / 8;
  localparam int IDX_W  = $clog2(BYTES);
  localparam int LEFT_W = $clog2(BYTES + 1);

  logic [IDX_W-1:0]  pk_idx;
  logic [WORD_W-1:0] pk_acc;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] up_sh;
  logic [LEFT_W-1:0] up_left;

  // little-endian lane steering: the byte at index k lands in lane k
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign merged[8*b +: 8] = (pk_idx == IDX_W'(b)) ? rd_byte : pk_acc[8*b +: 8];
  end

  assign pk_push  = rd_fire && ((pk_idx == IDX_W'(BYTES-1)) || last_byte);
  assign pk_word  = merged;
  assign up_valid = (up_left != '0);
  assign up_byte  = up_sh[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pk_idx  <= '0;
      pk_acc  <= '0;
      up_sh   <= '0;
      up_left <= '0;
    end else begin
      if (rd_fire) begin
        if (pk_push) begin
          pk_idx <= '0;
          pk_acc <= '0;
        end else begin
          pk_idx <= pk_idx + 1'b1;
          pk_acc <= merged;
        end
      end
      if (load) begin
        up_sh   <= load_word;
        up_left <= LEFT_W'(BYTES);
      end else if (wr_fire) begin
        up_sh   <= up_sh >> 8;
        up_left <= up_left - 1'b1;
      end
    end
  end

  // R8
  load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !up_valid);
  // R8
  fire_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> up_valid);
endmodule

// File: rtl/cfx_flag_gen.sv
module cfx_flag_gen
  import cfx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        active,
  input  logic                        dir_rx,
  input  logic [$clog2(DEPTH+1)-1:0]  count,
  output logic [FLG_N-1:0]            tx_flags,
  output logic [FLG_N-1:0]            rx_flags
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int HALF  = DEPTH / 2;

  fifo_flags_t base;
  fifo_flags_t tx_q;
  fifo_flags_t rx_q;

  always_comb begin
    base.active = 1'b1;
    base.empty  = (count == '0);
    base.avail  = (count != '0);
    base.full   = (count == CNT_W'(DEPTH));
    base.half   = dir_rx ? (count >= CNT_W'(HALF)) : (count <= CNT_W'(HALF));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= (active && !dir_rx) ? base : '0;
      rx_q <= (active &&  dir_rx) ? base : '0;
    end
  end

  assign tx_flags = tx_q;
  assign rx_flags = rx_q;

  // R11
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|tx_flags) && (|rx_flags)));
  // R11
  empty_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({tx_flags[FLG_EMPTY], tx_flags[FLG_AVAIL], rx_flags[FLG_EMPTY], rx_flags[FLG_AVAIL]}) <= 1);
endmodule

// File: rtl/cardfifo_xfer.sv
module cardfifo_xfer
  import cfx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  ctrl_wr,
  input  logic [1:0]                            ctrl_wdata,
  input  logic                                  len_wr,
  input  logic [LEN_W-1:0]                      len_wdata,
  input  logic                                  push_strobe,
  input  logic [WORD_W-1:0]                     push_data,
  input  logic                                  pop_strobe,
  output logic [WORD_W-1:0]                     pop_data,
  input  logic                                  status_poll,
  input  logic                                  card_data_ready,
  input  logic                                  rd_valid,
  input  logic [7:0]                            rd_data,
  output logic                                  rd_ready,
  output logic                                  wr_valid,
  output logic [7:0]                            wr_data,
  input  logic                                  wr_ready,
  output logic                                  xfer_enabled,
  output logic                                  data_end,
  output logic                                  block_end,
  output logic [FLG_N-1:0]                      tx_flags,
  output logic [FLG_N-1:0]                      rx_flags,
  output logic [LEN_W-$clog2(WORD_W/8):0]       word_count
);
  localparam int BYTES = WORD_W / 8;
  localparam int IDX_W = $clog2(BYTES);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int WC_W  = LEN_W - IDX_W + 1;

  // control and counter state
  logic             en_q;
  xfer_dir_e        dir_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic             hold_q;
  logic             dend_q;
  logic             bend_q;

  // FIFO wiring
  logic              f_push, f_pop, f_full, f_empty;
  logic [WORD_W-1:0] f_push_data, f_head;
  logic [CNT_W-1:0]  f_count;

  // lane wiring
  logic              pk_push, up_valid;
  logic [WORD_W-1:0] pk_word;
  logic [7:0]        up_byte;

  logic ctrl_load, cnt_nz, is_rx, rd_fire, wr_fire;
  logic eng_load, host_pop_ok, host_push_ok, flag_active;

  assign ctrl_load = ctrl_wr && ctrl_wdata[CTRL_EN_BIT];
  assign cnt_nz    = (cnt_q != '0);
  assign is_rx     = (dir_q == XFER_FROM_CARD);

  // card-to-FIFO intake
  assign rd_ready = en_q && is_rx && cnt_nz && card_data_ready && !hold_q && !f_full;
  assign rd_fire  = rd_valid && rd_ready;

  // FIFO-to-card output
  assign wr_valid = en_q && !is_rx && cnt_nz && up_valid;
  assign wr_data  = up_byte;
  assign wr_fire  = wr_valid && wr_ready;

  // host port arbitration: host pop takes the read side, the packer takes the write side
  assign host_pop_ok  = pop_strobe && !f_empty;
  assign eng_load     = en_q && !is_rx && cnt_nz && !up_valid && !f_empty && !host_pop_ok;
  assign host_push_ok = push_strobe && cnt_nz && !f_full && !pk_push;

  assign f_pop       = host_pop_ok || eng_load;
  assign f_push      = pk_push || host_push_ok;
  assign f_push_data = pk_push ? pk_word : push_data;
  assign pop_data    = f_empty ? '0 : f_head;

  assign flag_active = en_q && (cnt_nz || !f_empty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dir_q  <= XFER_TO_CARD;
      len_q  <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
      dend_q <= 1'b0;
      bend_q <= 1'b0;
    end else begin
      if (len_wr) len_q <= len_wdata;

      if (ctrl_wr) begin
        en_q  <= ctrl_wdata[CTRL_EN_BIT];
        dir_q <= xfer_dir_e'(ctrl_wdata[CTRL_DIR_BIT]);
      end else if (en_q && !cnt_nz && f_empty) begin
        en_q <= 1'b0;
      end

      if (ctrl_load)              cnt_q <= len_q;
      else if (rd_fire || wr_fire) cnt_q <= cnt_q - 1'b1;

      // a pop re-arms the hold even when a poll arrives in the same cycle
      if (ctrl_load)        hold_q <= 1'b0;
      else if (host_pop_ok) hold_q <= 1'b1;
      else if (status_poll) hold_q <= 1'b0;

      if (ctrl_load) begin
        dend_q <= 1'b0;
        bend_q <= 1'b0;
      end else if (en_q && !cnt_nz) begin
        dend_q <= 1'b1;
        bend_q <= 1'b1;
      end
    end
  end

  assign xfer_enabled = en_q;
  assign data_end     = dend_q;
  assign block_end    = bend_q;
  assign word_count   = WC_W'(({1'b0, cnt_q} + (LEN_W+1)'(BYTES-1)) >> IDX_W);

  cfx_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (f_push),
    .push_data (f_push_data),
    .pop       (f_pop),
    .head      (f_head),
    .count     (f_count),
    .full      (f_full),
    .empty     (f_empty)
  );

  cfx_byte_lane #(.WORD_W(WORD_W)) lane_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ctrl_load),
    .rd_fire   (rd_fire),
    .rd_byte   (rd_data),
    .last_byte (cnt_q == LEN_W'(1)),
    .pk_push   (pk_push),
    .pk_word   (pk_word),
    .load      (eng_load),
    .load_word (f_head),
    .wr_fire   (wr_fire),
    .up_valid  (up_valid),
    .up_byte   (up_byte)
  );

  cfx_flag_gen #(.DEPTH(DEPTH)) flags_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (flag_active),
    .dir_rx   (is_rx),
    .count    (f_count),
    .tx_flags (tx_flags),
    .rx_flags (rx_flags)
  );

  // R2
  cnt_nonrising_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_load |=> (cnt_q <= $past(cnt_q)));
  // R7
  hold_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop_ok && !ctrl_load) |=> !rd_ready);
  // R8
  wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !ctrl_wr) |=> (wr_valid && $stable(wr_data)));
  // R9
  end_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !cnt_nz && !ctrl_load) |=> (data_end && block_end));
  // R10
  auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !cnt_nz && f_empty && !ctrl_wr) |=> !xfer_enabled);
endmodule

// File: tb/cardfifo_xfer_tb_top.sv
module cardfifo_xfer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_wr;
  logic [1:0]  ctrl_wdata;
  logic        len_wr;
  logic [15:0] len_wdata;
  logic        push_strobe;
  logic [31:0] push_data;
  logic        pop_strobe;
  logic [31:0] pop_data;
  logic        status_poll;
  logic        card_data_ready;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        rd_ready;
  logic        wr_valid;
  logic [7:0]  wr_data;
  logic        wr_ready;
  logic        xfer_enabled;
  logic        data_end;
  logic        block_end;
  logic [4:0]  tx_flags;
  logic [4:0]  rx_flags;
  logic [14:0] word_count;

  always #5 clk = ~clk;

  cardfifo_xfer dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .len_wr(len_wr), .len_wdata(len_wdata), .push_strobe(push_strobe),
    .push_data(push_data), .pop_strobe(pop_strobe), .pop_data(pop_data),
    .status_poll(status_poll), .card_data_ready(card_data_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .xfer_enabled(xfer_enabled), .data_end(data_end), .block_end(block_end),
    .tx_flags(tx_flags), .rx_flags(rx_flags), .word_count(word_count)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [31:0] exp_words[$];
  logic [7:0]  exp_bytes[$];
  string       mon_req = "R3";
  logic [7:0]  src_mem [0:127];
  int          src_n = 0;
  int          src_idx = 0;
  bit          wr_toggle = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: capture handshakes before the edge, then card models and scoreboard monitor
  task automatic step();
    bit sf, kf, pf;
    logic [7:0]  wd;
    logic [31:0] pd;
    @(negedge clk);
    sf = rd_valid && rd_ready;
    kf = wr_valid && wr_ready;
    wd = wr_data;
    pf = pop_strobe;
    pd = pop_data;
    @(posedge clk);
    #1;
    if (sf) src_idx++;
    rd_valid = (src_idx < src_n);
    rd_data  = src_mem[src_idx[6:0]];
    if (kf) begin
      if (exp_bytes.size() == 0) begin
        tests++; fails++;
        $display("FAIL R8: actual byte %h expected none", wd);
      end else chk("R8", {24'h0, wd}, {24'h0, exp_bytes.pop_front()});
    end
    if (pf) begin
      if (exp_words.size() == 0) chk(mon_req, pd, 32'h0);
      else chk(mon_req, pd, exp_words.pop_front());
    end
    ctrl_wr = 0; len_wr = 0; push_strobe = 0; pop_strobe = 0; status_poll = 0;
    if (wr_toggle) wr_ready = ~wr_ready;
  endtask

  task automatic set_len(input logic [15:0] n);
    len_wr = 1; len_wdata = n; step();
  endtask

  task automatic ctrl(input logic [1:0] v);
    ctrl_wr = 1; ctrl_wdata = v; step();
  endtask

  task automatic host_push(input logic [31:0] w, input int nbytes);
    for (int i = 0; i < nbytes; i++) exp_bytes.push_back(w[8*i +: 8]);
    push_strobe = 1; push_data = w; step();
  endtask

  task automatic load_src(input int n, input int seed);
    for (int i = 0; i < n; i++) src_mem[i] = 8'(i * seed + 8'hA0);
    src_n = n; src_idx = 0;
    rd_valid = (n > 0); rd_data = src_mem[0];
    for (int w = 0; w < (n + 3) / 4; w++) begin
      logic [31:0] word = '0;
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < n) word[8*b +: 8] = src_mem[w * 4 + b];
      exp_words.push_back(word);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ctrl_wr = 0; ctrl_wdata = 0; len_wr = 0; len_wdata = 0;
    push_strobe = 0; push_data = 0; pop_strobe = 0; status_poll = 0;
    card_data_ready = 0; rd_valid = 0; rd_data = 0; wr_ready = 0;
    repeat (3) step();
    rst_n = 1;
    step();

    // R1 reset state
    chk("R1", {31'h0, xfer_enabled}, 0);
    chk("R1", {30'h0, data_end, block_end}, 0);
    chk("R1", {22'h0, tx_flags, rx_flags}, 0);
    chk("R1", {17'h0, word_count}, 0);
    chk("R1", {30'h0, rd_ready, wr_valid}, 0);

    // R12 push with counter zero is dropped; pop of empty FIFO gives zero
    push_strobe = 1; push_data = 32'hDEADBEEF; step(); step();
    mon_req = "R12"; pop_strobe = 1; step();

    // read of 10 bytes: little-endian packing and partial final word
    set_len(16'd10);
    card_data_ready = 0;
    load_src(10, 1);
    ctrl(2'b11);
    chk("R2", {17'h0, word_count}, 3);
    chk("R2", {31'h0, data_end}, 0);
    repeat (4) step();
    chk("R6", {31'h0, rd_ready}, 0);
    chk("R6", {17'h0, word_count}, 3);
    card_data_ready = 1;
    repeat (14) step();
    chk("R4", {17'h0, word_count}, 0);
    chk("R9", {30'h0, data_end, block_end}, 2'b11);
    chk("R11", {27'h0, rx_flags}, 5'b00101);
    chk("R11", {27'h0, tx_flags}, 0);
    chk("R10", {31'h0, xfer_enabled}, 1);
    mon_req = "R4";
    for (int i = 0; i < 3; i++) begin
      pop_strobe = 1; step(); status_poll = 1; step();
    end
    step(); step();
    chk("R10", {31'h0, xfer_enabled}, 0);
    chk("R10", {27'h0, rx_flags}, 0);
    chk("R3", exp_words.size(), 0);

    // read of 72 bytes: full stall, hold-off after pop, wrap of the FIFO
    set_len(16'd72);
    load_src(72, 7);
    ctrl(2'b11);
    repeat (80) step();
    chk("R5", {31'h0, rd_ready}, 0);
    chk("R5", {17'h0, word_count}, 2);
    chk("R11", {27'h0, rx_flags}, 5'b11101);
    mon_req = "R13";
    pop_strobe = 1; step();
    repeat (5) step();
    chk("R7", {31'h0, rd_ready}, 0);
    chk("R7", {17'h0, word_count}, 2);
    status_poll = 1; step();
    repeat (6) step();
    chk("R7", {17'h0, word_count}, 1);
    chk("R5", {31'h0, rd_ready}, 0);
    for (int g = 0; g < 200 && exp_words.size() > 0; g++) begin
      pop_strobe = 1; step(); status_poll = 1; step();
    end
    step(); step();
    chk("R13", exp_words.size(), 0);
    chk("R10", {31'h0, xfer_enabled}, 0);
    card_data_ready = 0;

    // write of 10 bytes from three words under back-pressure
    set_len(16'd10);
    wr_ready = 0;
    ctrl(2'b01);
    chk("R2", {30'h0, data_end, block_end}, 0);
    chk("R2", {17'h0, word_count}, 3);
    host_push(32'h44332211, 4);
    host_push(32'h88776655, 4);
    host_push(32'hCCBBAA99, 2);
    repeat (3) step();
    chk("R11", {27'h0, tx_flags}, 5'b10101);
    chk("R11", {27'h0, rx_flags}, 0);
    chk("R8", {23'h0, wr_valid, wr_data}, {23'h0, 1'b1, 8'h11});
    wr_toggle = 1;
    repeat (40) step();
    wr_toggle = 0; wr_ready = 1;
    chk("R8", exp_bytes.size(), 0);
    chk("R8", {31'h0, wr_valid}, 0);
    chk("R9", {30'h0, data_end, block_end}, 2'b11);
    chk("R10", {31'h0, xfer_enabled}, 0);
    chk("R10", {27'h0, tx_flags}, 0);
    push_strobe = 1; push_data = 32'h12345678; step(); step();
    chk("R12", {31'h0, wr_valid}, 0);
    mon_req = "R12"; pop_strobe = 1; step();

    // zero-length load ends immediately
    set_len(16'd0);
    ctrl(2'b11);
    chk("R9", {31'h0, data_end}, 0);
    chk("R10", {31'h0, xfer_enabled}, 1);
    step();
    chk("R9", {30'h0, data_end, block_end}, 2'b11);
    chk("R10", {31'h0, xfer_enabled}, 0);

    // maximum length rounding, then disable by control write
    set_len(16'hFFFF);
    ctrl(2'b01);
    chk("R2", {17'h0, word_count}, 16384);
    ctrl(2'b00);
    chk("R2", {31'h0, xfer_enabled}, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule